// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management-interface master that performs clause-22 PHY register reads and writes over an MDC clock line and a bidirectional MDIO data line. Software sees two registers behind a small register port. The command register holds a PHY address, a PHY register number, a direction flag and a self-clearing busy/start flag. A separate data register supplies the write value or receives the read value. Setting the start flag launches one management frame. The block divides the system clock down to MDC, shifts the frame out MSB first, releases the line while the PHY answers, and clears busy when the frame ends.

The frame sequencer is an enumerated state machine with these states:

- `ST_IDLE`: waits for busy to be set.
- `ST_ARM`: MDC is running and the line is still released. It waits for the first MDC falling edge, where it latches the write data and the address fields.
- `ST_PRE`: 32 preamble ones.
- `ST_SOF`: start bits 0,1.
- `ST_OP`: opcode, 1,0 for a read and 0,1 for a write.
- `ST_PHY`: five PHY address bits.
- `ST_REG`: five register bits.
- `ST_TA`: turnaround. A write drives 1,0; a read releases the line.
- `ST_DATA`: sixteen data bits.
- `ST_END`: one cycle that clears busy.

Every shifting state moves on to the next state, in the order listed, on the MDC falling edge that ends its last bit. `ST_END` returns to `ST_IDLE` after one cycle.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0, the data register reads 0, MDC is low and the MDIO output enable is low.
- R2: A command-register write with bit 0 set while busy is clear starts a frame. Command bit 0 then reads 1 from the cycle after that write for exactly 130*H+1 cycles and then reads 0, where H is the effective MDC half period.
- R3: MDC is low whenever no frame is in progress. During a frame, MDC toggles every H system clocks, where H = mdc_half, and a value of 0 counts as 1. The first rising edge comes H cycles after the frame starts, and MDC is low again when busy clears.
- R4: The frame has 64 bits, each starting at an MDC falling edge and sent MSB first. The bits are 32 ones, then 0,1, then the opcode (1,0 when command bit 1 is 0 for a read; 0,1 when command bit 1 is 1 for a write), then the PHY address from command bits [16:12], then the register number from command bits [8:4], then the turnaround, then 16 data bits. MDIO output changes only on MDC falling edges.
- R5: In a write frame the turnaround is driven 1 then 0. The data bits are the data register value in force at the first MDC falling edge, including a data write in that same cycle. Data-register writes after that edge do not change the frame.
- R6: In a read frame the output enable is low for the turnaround and all 16 data bits. MDIO input is sampled on MDC rising edges during the data bits. Once busy clears, the data register reads the 16 sampled bits, first sample in bit 15.
- R7: A command-register write while busy reads 1 is ignored, including a write in the final busy cycle. The fields and the frame in progress are unchanged, and no new frame starts.
- R8: The output enable is low while idle and during the arm phase before the first falling edge, and goes low after the final cycle of a frame.
- R9: With reg_sel = 0 the port reads the command register: busy in bit 0, direction in bit 1, register number in [8:4], PHY address in [16:12], all other bits 0. With reg_sel = 1 it reads the data register in bits [15:0], and bits [31:16] read 0.
- R10: A command write with bit 0 clear, while idle, stores the direction and address fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read value of the selected register |
| mdc_half | input | DIV_W (8) | MDC half period in system clocks, 0 counts as 1 |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen by the block |
| mdio_o | output | 1 | MDIO value driven while enabled |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two events can fall in the same cycle. The first is a data-register write arriving in the very cycle of the first MDC falling edge, where the frame latches its write data. The second is a command write landing in the last busy cycle, where completion clears busy. The bench provokes the first by counting cycles from the launch, using a one-cycle half period so that the first falling edge follows directly after the launch write, and again with a two-cycle half period. It provokes the second by waiting for cycle 130*H of the frame. The behavioural model then judges the outcome on every clock: the frame must carry the coincident data value, and the late command must leave the fields unchanged and must not start a second frame.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;

    localparam int CMD_BUSY_BIT = 0;
    localparam int CMD_DIR_BIT  = 1;
    localparam int CMD_REG_LSB  = 4;
    localparam int CMD_PHY_LSB  = 12;
    localparam int FIELD_W      = 5;
    localparam int DATA_W       = 16;
    localparam int PRE_LEN      = 32;
    localparam int CNT_W        = $clog2(PRE_LEN);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA,
        ST_END
    } mdio_state_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    assign limit     = (half == '0) ? '0 : half - 1'b1;
    assign tick      = run && (cnt == limit);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_wr,
    input  logic [FIELD_W-1:0] phy_addr,
    input  logic [FIELD_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data
);

    mdio_state_e              st, st_n;
    logic [CNT_W-1:0]         cnt, cnt_n;
    logic [2*FIELD_W-1:0]     hdr_sh;
    logic [DATA_W-1:0]        wr_sh;
    logic [DATA_W-1:0]        rd_sh;

    function automatic logic [CNT_W-1:0] last_idx(input mdio_state_e s);
        case (s)
            ST_PRE:          return CNT_W'(PRE_LEN - 1);
            ST_PHY, ST_REG:  return CNT_W'(FIELD_W - 1);
            ST_DATA:         return CNT_W'(DATA_W - 1);
            default:         return CNT_W'(1);
        endcase
    endfunction

    function automatic mdio_state_e follow(input mdio_state_e s);
        case (s)
            ST_PRE:  return ST_SOF;
            ST_SOF:  return ST_OP;
            ST_OP:   return ST_PHY;
            ST_PHY:  return ST_REG;
            ST_REG:  return ST_TA;
            ST_TA:   return ST_DATA;
            default: return ST_END;
        endcase
    endfunction

    // next-state decode
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: if (start) st_n = ST_ARM;
            ST_ARM: begin
                if (fall_tick) begin
                    st_n  = ST_PRE;
                    cnt_n = '0;
                end
            end
            ST_END: st_n = ST_IDLE;
            ST_PRE, ST_SOF, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA: begin
                if (fall_tick) begin
                    if (cnt == last_idx(st)) begin
                        st_n  = follow(st);
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_sh <= '0;
            wr_sh  <= '0;
            rd_sh  <= '0;
        end else begin
            if (st == ST_ARM && fall_tick) begin
                hdr_sh <= {phy_addr, reg_addr};
                wr_sh  <= wr_data;
            end
            if (fall_tick && (st == ST_PHY || st == ST_REG))
                hdr_sh <= {hdr_sh[2*FIELD_W-2:0], 1'b0};
            if (fall_tick && st == ST_DATA)
                wr_sh <= {wr_sh[DATA_W-2:0], 1'b0};
            if (rise_tick && st == ST_DATA && !is_wr)
                rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b1;
        done    = 1'b0;
        unique case (st)
            ST_IDLE, ST_ARM: ;
            ST_END:  done = 1'b1;
            ST_PRE:  mdio_oe = 1'b1;
            ST_SOF: begin
                mdio_oe = 1'b1;
                mdio_o  = (cnt == CNT_W'(1));
            end
            ST_OP: begin
                mdio_oe = 1'b1;
                mdio_o  = is_wr ? (cnt == CNT_W'(1)) : (cnt == '0);
            end
            ST_PHY, ST_REG: begin
                mdio_oe = 1'b1;
                mdio_o  = hdr_sh[2*FIELD_W-1];
            end
            ST_TA: begin
                mdio_oe = is_wr;
                mdio_o  = (cnt == '0);
            end
            ST_DATA: begin
                mdio_oe = is_wr;
                mdio_o  = wr_sh[DATA_W-1];
            end
            default: ;
        endcase
    end

    assign rd_data = rd_sh;

    assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_tick));

    assert_release_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mdio_oe);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_ctrl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [DIV_W-1:0] mdc_half,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);

    logic               busy;
    logic               dir_wr;
    logic [FIELD_W-1:0] phy_f;
    logic [FIELD_W-1:0] reg_f;
    logic [DATA_W-1:0]  data_q;
    logic               cmd_wr, dat_wr;
    logic               done_w;
    logic               rise_w, fall_w;
    logic [DATA_W-1:0]  rd_w;
    logic [DATA_W-1:0]  wr_live;

    assign cmd_wr  = reg_wr && !reg_sel;
    assign dat_wr  = reg_wr && reg_sel;
    assign wr_live = dat_wr ? reg_wdata[DATA_W-1:0] : data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            dir_wr <= 1'b0;
            phy_f  <= '0;
            reg_f  <= '0;
        end else if (cmd_wr && !busy) begin
            busy   <= reg_wdata[CMD_BUSY_BIT];
            dir_wr <= reg_wdata[CMD_DIR_BIT];
            phy_f  <= reg_wdata[CMD_PHY_LSB +: FIELD_W];
            reg_f  <= reg_wdata[CMD_REG_LSB +: FIELD_W];
        end else if (done_w) begin
            busy   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (done_w && !dir_wr)
            data_q <= rd_w;
        else if (dat_wr)
            data_q <= reg_wdata[DATA_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[DATA_W-1:0] = data_q;
        end else begin
            reg_rdata[CMD_BUSY_BIT]                = busy;
            reg_rdata[CMD_DIR_BIT]                 = dir_wr;
            reg_rdata[CMD_REG_LSB +: FIELD_W]      = reg_f;
            reg_rdata[CMD_PHY_LSB +: FIELD_W]      = phy_f;
        end
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy && !done_w),
        .half      (mdc_half),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (busy),
        .is_wr     (dir_wr),
        .phy_addr  (phy_f),
        .reg_addr  (reg_f),
        .wr_data   (wr_live),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done_w),
        .rd_data   (rd_w)
    );

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && reg_wdata[CMD_BUSY_BIT]) |=> busy);

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |-> busy);

    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_w) |=> ($stable(phy_f) && $stable(reg_f) && $stable(dir_wr)));

endmodule

// File: tb/mdio_cmd_ctrl_test.sv
module mdio_cmd_ctrl_test;

    localparam int DW = 8;
    localparam logic [31:0] CMD_MASK = 32'h0001_F1F3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr, reg_sel;
    logic [31:0]   reg_wdata, reg_rdata;
    logic [DW-1:0] mdc_half;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    int n_run  = 0;
    int n_fail = 0;

    // behavioural model state
    bit          m_active = 0;
    int          m_t = 0;
    int          m_h = 1;
    bit          m_wr = 0;
    logic [4:0]  m_phy = '0, m_reg = '0;
    logic [15:0] m_dreg = '0, m_lat = '0, m_rd = '0;
    logic [31:0] m_cmd = '0;
    int          j;
    bit          e_oe, e_o, e_mdc;

    always #4 clk = ~clk;

    mdio_cmd_ctrl #(.DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_half(mdc_half),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (t=%0d)", req, what, act, exp, m_t);
        end
    endtask

    function automatic bit fbit(input int k);
        if (k < 32) return 1'b1;
        if (k == 32) return 1'b0;
        if (k == 33) return 1'b1;
        if (k == 34) return !m_wr;
        if (k == 35) return m_wr;
        if (k < 41) return m_phy[40-k];
        if (k < 46) return m_reg[45-k];
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        return m_lat[63-k];
    endfunction

    // model advance at the clock edge (inputs are driven 1 ns after edges)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0;
        end else begin
            if (reg_wr && reg_sel) m_dreg = reg_wdata[15:0];
            if (m_active) begin
                m_t++;
                if (m_t == 2*m_h) m_lat = m_dreg;
                if (m_t > 130*m_h) begin
                    m_active = 0;
                    m_cmd[0] = 1'b0;
                    if (!m_wr) m_dreg = m_rd;
                end
            end else if (reg_wr && !reg_sel) begin
                m_cmd = reg_wdata & CMD_MASK;
                if (reg_wdata[0]) begin
                    m_active = 1;
                    m_t   = 0;
                    m_h   = (mdc_half == 0) ? 1 : int'(mdc_half);
                    m_wr  = reg_wdata[1];
                    m_phy = reg_wdata[16:12];
                    m_reg = reg_wdata[8:4];
                end
            end
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_active) begin
                e_mdc = ((m_t / m_h) % 2) == 1;
                j = (m_t < 2*m_h) ? -1 : (m_t / (2*m_h)) - 1;
                e_oe = (j >= 0 && j < 64) && ((j < 46) || m_wr);
                e_o  = (j >= 0 && j < 64) ? fbit(j) : 1'b1;
                check(mdc == e_mdc, "R3", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
                check(mdio_oe == e_oe, "R6 R8", "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
                if (e_oe)
                    check(mdio_o == e_o, "R4 R5", "mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
                if (!reg_wr && !reg_sel)
                    check(reg_rdata[0] == 1'b1, "R2", "busy", {31'd0, reg_rdata[0]}, 32'd1);
                mdio_i = (!m_wr && j >= 48 && j < 64) ? m_rd[63-j] : 1'b1;
            end else begin
                mdio_i = 1'b1;
                check(mdc == 1'b0, "R3", "idle mdc", {31'd0, mdc}, 32'd0);
                check(mdio_oe == 1'b0, "R8", "idle mdio_oe", {31'd0, mdio_oe}, 32'd0);
                if (!reg_wr && !reg_sel)
                    check(reg_rdata[0] == 1'b0, "R2", "idle busy", {31'd0, reg_rdata[0]}, 32'd0);
            end
        end
    end

    task automatic cmd_write(input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic data_write(input logic [15:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = {16'hDEAD, v};
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic read_check(input bit sel, input string req, input logic [31:0] exp);
        @(posedge clk); #1;
        reg_sel = sel;
        @(negedge clk);
        check(reg_rdata == exp, req, sel ? "data reg" : "cmd reg", reg_rdata, exp);
        @(posedge clk); #1;
        reg_sel = 1'b0;
    endtask

    task automatic wait_t(input int n);
        while (!(m_active && m_t == n)) begin @(posedge clk); #1; end
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (m_active) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] cmd(input bit wr, input bit go,
                                        input logic [4:0] phy, input logic [4:0] rg);
        return {15'd0, phy, 3'd0, rg, 2'd0, wr, go};
    endfunction

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; mdc_half = 8'd2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "mdc/oe after reset",
              {30'd0, mdc, mdio_oe}, 32'd0);
        read_check(1'b0, "R1", 32'd0);
        read_check(1'b1, "R1", 32'd0);

        // R10 fields stored without launch, R9 field positions and zero bits
        cmd_write(32'hABCD_EEEE);
        repeat (8) @(posedge clk);
        read_check(1'b0, "R9 R10", 32'hABCD_EEEE & CMD_MASK);
        cmd_write(cmd(1'b0, 1'b0, 5'd5, 5'h13));
        read_check(1'b0, "R10", m_cmd);

        // write frame, data loaded before launch
        data_write(16'hA5C3);
        read_check(1'b1, "R9", 32'h0000_A5C3);
        cmd_write(cmd(1'b1, 1'b1, 5'd5, 5'h13));
        wait_idle();
        read_check(1'b0, "R2 R9", cmd(1'b1, 1'b0, 5'd5, 5'h13));
        read_check(1'b1, "R5", 32'h0000_A5C3);

        // read frame, H = 3
        mdc_half = 8'd3;
        m_rd = 16'h8001;
        cmd_write(cmd(1'b0, 1'b1, 5'h1F, 5'h00));
        wait_idle();
        read_check(1'b1, "R6", 32'h0000_8001);

        // H = 1: data written the cycle after launch coincides with first fall
        mdc_half = 8'd1;
        data_write(16'h1111);
        cmd_write(cmd(1'b1, 1'b1, 5'h0A, 5'h1F));
        data_write(16'h2222);
        data_write(16'h3333);
        wait_idle();
        check(m_lat == 16'h2222, "R5", "model latch", {16'd0, m_lat}, 32'h2222);
        read_check(1'b1, "R5", 32'h0000_3333);

        // H = 2: coincident data write, busy writes mid-frame and in last cycle
        mdc_half = 8'd2;
        data_write(16'h4444);
        cmd_write(cmd(1'b1, 1'b1, 5'h11, 5'h0C));
        wait_t(2);
        data_write(16'h5555);
        wait_t(40);
        cmd_write(cmd(1'b0, 1'b1, 5'h03, 5'h07));
        wait_t(130*2 - 1);
        cmd_write(cmd(1'b0, 1'b1, 5'h1E, 5'h01));
        wait_idle();
        check(m_lat == 16'h5555, "R5", "model latch", {16'd0, m_lat}, 32'h5555);
        read_check(1'b0, "R7", cmd(1'b1, 1'b0, 5'h11, 5'h0C));
        repeat (6) @(posedge clk);
        read_check(1'b0, "R7", cmd(1'b1, 1'b0, 5'h11, 5'h0C));

        // half period 0 behaves as 1, read frame
        mdc_half = 8'd0;
        m_rd = 16'h7E5A;
        cmd_write(cmd(1'b0, 1'b1, 5'h00, 5'h01));
        wait_idle();
        read_check(1'b1, "R3 R6", 32'h0000_7E5A);
        read_check(1'b0, "R2", cmd(1'b0, 1'b0, 5'h00, 5'h01));

        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule